// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible control and status store for an eight-channel DMA engine. Three 32-bit words are reachable through a simple read/write port that uses byte offsets. The control word holds one 4-bit field per channel. Each field carries a two-bit transfer mode and a direction bit, and these drive the channel datapaths directly. The enable word holds one interrupt enable per channel. It also has a row of write-only start bits, and each start bit sends a single-cycle kick to its channel.

The status word gathers what the channels report. A channel's completion pulse sets its interrupt flag. A channel's fault pulse sets that channel's interrupt flag and its error flag together. Software clears flags by writing ones over them. The upper half of the status word shows each channel's live two-bit activity state, and software cannot change it. One level interrupt line stays high for as long as any channel has its interrupt flag set while that channel's enable is also set. The per-channel address, size and link words that follow at offset 0x20 and above belong to the channel datapaths. This bank does not decode them.

Top module: `dmarb_regbank`

## Requirements
- R1: After reset, every stored bit is zero. The read data, the interrupt line, the mode and direction outputs and the start outputs are all low.
- R2: A write to offset 0x00 loads channel n's mode from data bits [4n+1:4n] and its direction from bit 4n+2. The values appear on `ch_mode[2n+1:2n]` and `ch_dir[n]` after the next edge. A read of 0x00 returns the same layout, with bit 4n+3 always zero.
- R3: A write to offset 0x08 stores bits [7:0] as the per-channel interrupt enables, and these read back in the same place. Bits [15:8] of that write pulse `ch_start[7:0]` high for exactly the following cycle. Bits [31:8] always read as zero.
- R4: A high `ch_event[n]` sets interrupt flag n, which is bit n of the status word at offset 0x10.
- R5: A high `ch_error[n]` sets interrupt flag n and error flag n (status bit n+8) in the same cycle.
- R6: A write to 0x10 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0.
- R7: When a set from R4 or R5 and a clear from R6 hit the same flag in the same cycle, the flag ends up set.
- R8: Status bits [17+2n:16+2n] return `ch_state[2n+1:2n]` as sampled at the read edge. Writes to those bits change nothing.
- R9: `irq` is high exactly when some channel has both its interrupt flag and its enable set.
- R10: A read of any offset other than 0x00, 0x08 or 0x10 returns zero, and a write to such an offset changes no state.
- R11: `rdata` carries the addressed word in the cycle after `rd_en` is high, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| ch_event | input | 8 | Per-channel completion pulse |
| ch_error | input | 8 | Per-channel fault pulse |
| ch_state | input | 16 | Per-channel two-bit activity state |
| ch_mode | output | 16 | Per-channel two-bit mode |
| ch_dir | output | 8 | Per-channel direction |
| ch_start | output | 8 | Per-channel one-cycle start pulse |
| irq | output | 1 | Level interrupt |

## Verification
Every stored result is due one clock edge after its stimulus. This covers flags, enables, modes and start pulses. The interrupt line follows the flags with no further register, so it settles in that same cycle. Read data arrives one edge after `rd_en`. It reflects the store as it stood before that edge, together with `ch_state` as sampled at that edge. The bench works out each expected value from its own model before the edge, updates the model, and then compares all outputs 1 ns after the edge. This gives every check exactly one register stage of latency. Directed cases cover the clear-versus-set collision, writes to the read-only state bits and to unmapped offsets, and start bits, and random traffic mixes all of these.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
    localparam int CH_NUM    = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NIB_W     = 4;
    localparam int MODE_W    = 2;
    localparam int ST_W      = 2;
    localparam int ERR_LSB   = 8;
    localparam int START_LSB = 8;
    localparam int STATE_LSB = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } ch_mode_e;

    typedef struct packed {
        logic     dir;
        ch_mode_e mode;
    } ch_cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [NIB_W-1:0] cfg_to_nibble(ch_cfg_t c);
        return {1'b0, c.dir, c.mode};
    endfunction

    function automatic ch_cfg_t nibble_to_cfg(logic [NIB_W-1:0] nib);
        ch_cfg_t c;
        c.dir  = nib[MODE_W];
        c.mode = ch_mode_e'(nib[MODE_W-1:0]);
        return c;
    endfunction

    function automatic logic write_hit(bus_req_t r, logic [ADDR_W-1:0] ofs);
        return r.wr && (r.addr == ofs);
    endfunction
endpackage

// File: rtl/dmarb_cfg_regs.sv
module dmarb_cfg_regs
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    output ch_cfg_t [NUM_CH-1:0]   cfg_q,
    output logic    [NUM_CH-1:0]   ien_q,
    output logic    [NUM_CH-1:0]   start_q
);
    logic wr_ctrl;
    logic wr_ien;
    logic unused_cfg;

    assign wr_ctrl    = write_hit(req, OFS_CTRL);
    assign wr_ien     = write_hit(req, OFS_IEN);
    assign unused_cfg = ^{req.rd, req.wdata};

    for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[n] <= '0;
            end else if (wr_ctrl) begin
                cfg_q[n] <= nibble_to_cfg(req.wdata[NIB_W*n +: NIB_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            start_q <= '0;
        end else begin
            if (wr_ien) begin
                ien_q <= req.wdata[NUM_CH-1:0];
            end
            start_q <= wr_ien ? req.wdata[START_LSB +: NUM_CH] : '0;
        end
    end
endmodule

// File: rtl/dmarb_event_flags.sv
module dmarb_event_flags
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NUM_CH-1:0] ch_event,
    input  logic [NUM_CH-1:0] ch_error,
    output logic [NUM_CH-1:0] int_q,
    output logic [NUM_CH-1:0] err_q
);
    logic clr;
    logic unused_flags;

    assign clr          = write_hit(req, OFS_STAT);
    assign unused_flags = ^{req.rd, req.wdata};

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        logic int_keep;
        logic err_keep;
        assign int_keep = int_q[n] & ~(clr & req.wdata[n]);
        assign err_keep = err_q[n] & ~(clr & req.wdata[ERR_LSB + n]);

        always_ff @(posedge clk) begin
            if (rst) begin
                int_q[n] <= 1'b0;
                err_q[n] <= 1'b0;
            end else begin
                int_q[n] <= ch_event[n] | ch_error[n] | int_keep;
                err_q[n] <= ch_error[n] | err_keep;
            end
        end
    end
endmodule

// File: rtl/dmarb_read_mux.sv
module dmarb_read_mux
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_req_t                req,
    input  ch_cfg_t [NUM_CH-1:0]    cfg,
    input  logic    [NUM_CH-1:0]    ien,
    input  logic    [NUM_CH-1:0]    int_flags,
    input  logic    [NUM_CH-1:0]    err_flags,
    input  logic    [ST_W*NUM_CH-1:0] ch_state,
    output logic    [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] ien_word;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] sel_word;
    logic              unused_rd;

    assign unused_rd = ^{req.wr, req.wdata};

    always_comb begin
        ctrl_word = '0;
        ien_word  = '0;
        stat_word = '0;
        ien_word[NUM_CH-1:0] = ien;
        for (int n = 0; n < NUM_CH; n++) begin
            ctrl_word[NIB_W*n +: NIB_W]           = cfg_to_nibble(cfg[n]);
            stat_word[n]                          = int_flags[n];
            stat_word[ERR_LSB + n]                = err_flags[n];
            stat_word[STATE_LSB + ST_W*n +: ST_W] = ch_state[ST_W*n +: ST_W];
        end
    end

    always_comb begin
        case (req.addr)
            OFS_CTRL: sel_word = ctrl_word;
            OFS_IEN:  sel_word = ien_word;
            OFS_STAT: sel_word = stat_word;
            default:  sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= req.rd ? sel_word : '0;
        end
    end
endmodule

// File: rtl/dmarb_regbank.sv
module dmarb_regbank
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH-1:0]        ch_event,
    input  logic [NUM_CH-1:0]        ch_error,
    input  logic [ST_W*NUM_CH-1:0]   ch_state,
    output logic [MODE_W*NUM_CH-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_dir,
    output logic [NUM_CH-1:0]        ch_start,
    output logic                     irq
);
    bus_req_t             req;
    ch_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]    irq_en;
    logic [NUM_CH-1:0]    int_flags;
    logic [NUM_CH-1:0]    err_flags;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, wdata: wdata};

    dmarb_cfg_regs #(.NUM_CH(NUM_CH)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .cfg_q   (cfg),
        .ien_q   (irq_en),
        .start_q (ch_start)
    );

    dmarb_event_flags #(.NUM_CH(NUM_CH)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .ch_event (ch_event),
        .ch_error (ch_error),
        .int_q    (int_flags),
        .err_q    (err_flags)
    );

    dmarb_read_mux #(.NUM_CH(NUM_CH)) rmux_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cfg       (cfg),
        .ien       (irq_en),
        .int_flags (int_flags),
        .err_flags (err_flags),
        .ch_state  (ch_state),
        .rdata     (rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_out
        assign ch_mode[MODE_W*n +: MODE_W] = cfg[n].mode;
        assign ch_dir[n]                   = cfg[n].dir;
    end

    assign irq = |(int_flags & irq_en);
endmodule

// File: rtl/dmarb_regbank_chk.sv
module dmarb_regbank_chk
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        rdata,
    input logic [NUM_CH-1:0]        ch_event,
    input logic [NUM_CH-1:0]        ch_error,
    input logic [MODE_W*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]        ch_dir,
    input logic [NUM_CH-1:0]        ch_start,
    input logic                     irq,
    input logic [NUM_CH-1:0]        int_flags,
    input logic [NUM_CH-1:0]        err_flags,
    input logic [NUM_CH-1:0]        irq_en
);
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !($past(wr_en) && $past(addr) == OFS_CTRL) |-> ($stable(ch_mode) && $stable(ch_dir)));

    assert_start_src_R3: assert property (@(posedge clk) disable iff (rst)
        (ch_start != '0) |-> ($past(wr_en) && $past(addr) == OFS_IEN));

    assert_event_sets_R4: assert property (@(posedge clk) disable iff (rst)
        ((ch_event | ch_error) != '0) |=> (($past(ch_event | ch_error) & ~int_flags) == '0));

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        ((int_flags & ~$past(int_flags) & ~$past(ch_event | ch_error)) == '0));

    assert_error_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (ch_error != '0) |=> (($past(ch_error) & ~err_flags) == '0));

    assert_clear_src_R6: assert property (@(posedge clk) disable iff (rst)
        ((~int_flags & $past(int_flags)) != '0) |-> ($past(wr_en) && $past(addr) == OFS_STAT));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((int_flags != '0) && (irq_en != '0)));

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata == '0));
endmodule

bind dmarb_regbank dmarb_regbank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .ch_event  (ch_event),
    .ch_error  (ch_error),
    .ch_mode   (ch_mode),
    .ch_dir    (ch_dir),
    .ch_start  (ch_start),
    .irq       (irq),
    .int_flags (int_flags),
    .err_flags (err_flags),
    .irq_en    (irq_en)
);

// File: tb/dmarb_regbank_tb.sv
module dmarb_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  ch_event = '0;
    logic [7:0]  ch_error = '0;
    logic [15:0] ch_state = '0;
    logic [15:0] ch_mode;
    logic [7:0]  ch_dir;
    logic [7:0]  ch_start;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  m_flag = '0, m_err = '0, m_en = '0, m_dir = '0;
    logic [15:0] m_mode = '0;

    always #5 clk = ~clk;

    dmarb_regbank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_event(ch_event), .ch_error(ch_error),
        .ch_state(ch_state), .ch_mode(ch_mode), .ch_dir(ch_dir),
        .ch_start(ch_start), .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] w = '0;
        case (a)
            8'h00: for (int n = 0; n < 8; n++) w[4*n +: 3] = {m_dir[n], m_mode[2*n +: 2]};
            8'h08: w[7:0] = m_en;
            8'h10: w = {ch_state, m_err, m_flag};
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string rtag(input logic [7:0] a);
        case (a)
            8'h00: return "R2 ctrl read";
            8'h08: return "R3 enable read";
            8'h10: return "R6/R8 status read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    task automatic step(input string tag);
        logic [31:0] exp_rd;
        logic [7:0]  exp_start;
        logic [7:0]  ci, ce;
        string       rt;
        exp_rd    = rd_en ? model_read(addr) : '0;
        rt        = rd_en ? rtag(addr) : "R11 idle read";
        exp_start = (wr_en && addr == 8'h08) ? wdata[15:8] : '0;
        ci = (wr_en && addr == 8'h10) ? wdata[7:0]  : '0;
        ce = (wr_en && addr == 8'h10) ? wdata[15:8] : '0;
        m_flag = (m_flag & ~ci) | ch_event | ch_error;
        m_err  = (m_err & ~ce) | ch_error;
        if (wr_en && addr == 8'h08) m_en = wdata[7:0];
        if (wr_en && addr == 8'h00)
            for (int n = 0; n < 8; n++) begin
                m_mode[2*n +: 2] = wdata[4*n +: 2];
                m_dir[n]         = wdata[4*n + 2];
            end
        @(posedge clk); #1;
        chk(rdata === exp_rd, {tag, " ", rt}, rdata, exp_rd);
        chk(irq === |(m_flag & m_en), {tag, " R9 irq"}, {31'b0, irq}, {31'b0, |(m_flag & m_en)});
        chk({ch_dir, ch_mode} === {m_dir, m_mode}, {tag, " R2 mode/dir"}, {8'b0, ch_dir, ch_mode}, {8'b0, m_dir, m_mode});
        chk(ch_start === exp_start, {tag, " R3 start"}, {24'b0, ch_start}, {24'b0, exp_start});
        wr_en = 1'b0; rd_en = 1'b0; ch_event = '0; ch_error = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; addr = a; wdata = d; step(tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        rd_en = 1'b1; addr = a; step(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state visible on every output and register
        chk(rdata === '0 && irq === 1'b0 && ch_mode === '0 && ch_dir === '0 && ch_start === '0,
            "R1 reset outputs", {rdata[15:0], ch_mode}, 32'h0);
        rd(8'h00, "R1"); rd(8'h08, "R1"); rd(8'h10, "R1");

        // R2: all-ones write, spare nibble bit reads zero
        wr(8'h00, 32'hFFFF_FFFF, "R2"); rd(8'h00, "R2");
        wr(8'h00, 32'h8421_5A3C, "R2"); rd(8'h00, "R2");

        // R3: enables plus start pulse lasting one cycle
        wr(8'h08, 32'hFFFF_A55A, "R3"); rd(8'h08, "R3");
        step("R3 pulse gone");

        // R4 / R9: event raises irq on an enabled channel
        ch_event = 8'h02; step("R4");
        rd(8'h10, "R4");
        // R5: error sets both lanes
        ch_error = 8'h80; step("R5");
        rd(8'h10, "R5");
        // R6: partial clear
        wr(8'h10, 32'h0000_0002, "R6"); rd(8'h10, "R6");
        // R7: clear and set collide on channel 7
        ch_error = 8'h80; ch_event = 8'h01;
        wr(8'h10, 32'h0000_8081, "R7"); rd(8'h10, "R7");
        // R8: state lanes read-only, follow input
        ch_state = 16'hC3A5; wr(8'h10, 32'hFFFF_0000, "R8"); rd(8'h10, "R8");
        ch_state = 16'h1E0F; rd(8'h10, "R8");
        // R9: disabling enables drops irq while flags remain
        wr(8'h08, 32'h0000_0000, "R9"); rd(8'h10, "R9");
        // R10: unmapped writes change nothing, reads return zero
        wr(8'h04, 32'hFFFF_FFFF, "R10"); wr(8'h0C, 32'hFFFF_FFFF, "R10");
        wr(8'h20, 32'hFFFF_FFFF, "R10"); wr(8'h14, 32'hFFFF_FFFF, "R10");
        rd(8'h04, "R10"); rd(8'h20, "R10");
        rd(8'h00, "R10"); rd(8'h08, "R10"); rd(8'h10, "R10");
        // R11: no strobe means zero read data
        addr = 8'h10; step("R11");

        for (int i = 0; i < 600; i++) begin
            logic [7:0] offs [7] = '{8'h00, 8'h08, 8'h10, 8'h10, 8'h04, 8'h0C, 8'h20};
            addr     = offs[$urandom % 7];
            wr_en    = ($urandom % 3) == 0;
            rd_en    = ($urandom % 2) == 0;
            wdata    = $urandom;
            ch_event = 8'($urandom & $urandom & $urandom);
            ch_error = 8'($urandom & $urandom & $urandom & $urandom);
            ch_state = 16'($urandom);
            step("RND");
        end
        finish_run();
    end
endmodule